// File: doc/BRIEF.md
# Two-Output Level Interrupt Controller

This block collects thirty-two level-sensitive interrupt request lines and presents them to a processor as two request wires: a fast request and a normal request. Exactly one line, fixed by a parameter (line 8 by default), is steered to the fast request. Every other line goes to the normal request. Each line is gated by one bit of an enable mask before it contributes to either wire. The pending vector is simply the present level of the inputs. Nothing is latched, so a source clears its request by dropping its line.

Software reaches the block through a small 32-bit register port. Offset 0x48 holds the enable mask and can be read and written. Offset 0x44 is read-only and returns the pending lines after masking. Every other offset reads as zero and ignores writes. After reset the mask comes up with two lines (11 and 16) disabled and all others enabled. Both request wires are registered and follow a change on an input or on the mask one clock later.

Top module: `ic_fast_split`

## Requirements
- R1: Each pending bit equals the present level of its input line with no latching; when an input drops, its status bit reads 0 on the next status read.
- R2: The fast request output is driven only by input line 8 (parameter FAST_LINE) ANDed with mask bit 8.
- R3: The normal request output is the OR of all input lines except line 8, each ANDed with its mask bit; line 8 never affects it.
- R4: Both request outputs are registered: they reflect the inputs and the mask present before a rising edge, and appear after that edge.
- R5: A read of byte offset 0x44 returns the input vector ANDed with the enable mask, bit n for line n.
- R6: A read of byte offset 0x48 returns the enable mask, bit n for line n.
- R7: A write to offset 0x48 replaces the whole mask at the clock edge. A read of 0x48 in the same cycle returns the previous mask.
- R8: Writes to any offset other than 0x48 leave the mask unchanged.
- R9: A read of any offset other than 0x44 and 0x48 returns zero.
- R10: During and after synchronous active-low reset, the mask equals 0xFFFEF7FF (lines 11 and 16 disabled), and both request outputs and the read data are 0.
- R11: Read data is registered. It is loaded at the edge that samples a read strobe and holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive interrupt inputs, bit n is line n |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for this cycle |
| reg_rd | input | 1 | Read strobe for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| req_normal | output | 1 | Normal interrupt request to the processor |
| req_fast | output | 1 | Fast interrupt request to the processor |

## Verification
Three functions can share one cycle: a mask write, a read of the mask or of the status, and a change on the input lines. In that cycle the read and the request outputs must still use the old mask, and the new mask takes effect only from the next edge. The bench provokes this in directed steps that write the mask and read it, or read the status, in the same cycle while line 8 and a normal line toggle. Random steps mix strobes, offsets and line patterns freely. A bench model judges every cycle, and it applies the mask update only after it has computed that cycle's outputs.

// File: rtl/ic_pkg.sv
// Shared constants and types for the two-output interrupt controller.
// Assumes a byte-addressed register port with 32-bit data.
package ic_pkg;

    localparam int unsigned IC_DATA_W = 32;

    // Register select produced by the address decoder.
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2
    } ic_sel_e;

endpackage

// File: rtl/ic_addr_decode.sv
// Decodes the byte offset of a register access into a register select.
// Assumes the full offset is compared, so aliases never decode.
module ic_addr_decode
    import ic_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned STATUS_OFS = 8'h44,
    parameter int unsigned ENABLE_OFS = 8'h48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output ic_sel_e           sel,
    output logic              mask_wr
);

    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] ENABLE_A = ADDR_W'(ENABLE_OFS);

    // Map the offset onto one register or none.
    always_comb begin
        if (addr == STATUS_A) begin
            sel = SEL_STATUS;
        end else if (addr == ENABLE_A) begin
            sel = SEL_ENABLE;
        end else begin
            sel = SEL_NONE;
        end
    end

    // Only the enable register accepts writes.
    always_comb begin
        mask_wr = wr && (sel == SEL_ENABLE);
    end

endmodule

// File: rtl/ic_mask_reg.sv
// Holds the per-line enable mask.
// Assumes synchronous active-low reset; the reset pattern is a parameter.
module ic_mask_reg #(
    parameter int unsigned          LINES      = 32,
    parameter logic [LINES-1:0]     MASK_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LINES-1:0] load_val,
    output logic [LINES-1:0] mask
);

    // Load a new mask on a decoded write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= MASK_RESET;
        end else if (load) begin
            mask <= load_val;
        end
    end

endmodule

// File: rtl/ic_route.sv
// Splits the masked pending vector between the fast and normal request
// wires and registers each wire. Assumes FAST_LINE < LINES.
module ic_route #(
    parameter int unsigned LINES     = 32,
    parameter int unsigned FAST_LINE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] active,
    output logic             req_normal,
    output logic             req_fast
);

    logic [LINES-1:0] fast_part;
    logic [LINES-1:0] normal_part;

    // Steer each line to exactly one of the two request groups.
    for (genvar i = 0; i < LINES; i++) begin : g_steer
        if (i == FAST_LINE) begin : g_fast
            assign fast_part[i]   = active[i];
            assign normal_part[i] = 1'b0;
        end else begin : g_normal
            assign fast_part[i]   = 1'b0;
            assign normal_part[i] = active[i];
        end
    end

    // Register the OR of each group toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_normal <= 1'b0;
            req_fast   <= 1'b0;
        end else begin
            req_normal <= |normal_part;
            req_fast   <= |fast_part;
        end
    end

endmodule

// File: rtl/ic_readback.sv
// Registered read-data path for the register port.
// Assumes the select is decoded from the offset in the same cycle.
module ic_readback
    import ic_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  ic_sel_e           sel,
    input  logic [DATA_W-1:0] status_val,
    input  logic [DATA_W-1:0] enable_val,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rd_mux;

    // Choose the word for the selected register; unknown offsets give zero.
    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = status_val;
            SEL_ENABLE: rd_mux = enable_val;
            default:    rd_mux = '0;
        endcase
    end

    // Capture the word on a read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/ic_fast_split.sv
// Top of the two-output level interrupt controller. Pending lines are the
// live input levels; the mask gates them; one line feeds the fast request.
// Assumes inputs are already synchronous to clk.
module ic_fast_split
    import ic_pkg::*;
#(
    parameter int unsigned          LINES      = 32,
    parameter int unsigned          FAST_LINE  = 8,
    parameter int unsigned          ADDR_W     = 8,
    parameter int unsigned          STATUS_OFS = 8'h44,
    parameter int unsigned          ENABLE_OFS = 8'h48,
    parameter logic [LINES-1:0]     MASK_RESET = 32'hFFFE_F7FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_lines,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    output logic              req_normal,
    output logic              req_fast
);

    ic_sel_e          sel;
    logic             mask_wr;
    logic [LINES-1:0] en_mask;
    logic [LINES-1:0] masked;

    // Pending bits are the live levels, gated by the enable mask.
    always_comb begin
        masked = irq_lines & en_mask;
    end

    ic_addr_decode #(
        .ADDR_W     (ADDR_W),
        .STATUS_OFS (STATUS_OFS),
        .ENABLE_OFS (ENABLE_OFS)
    ) u_decode (
        .addr    (reg_addr),
        .wr      (reg_wr),
        .sel     (sel),
        .mask_wr (mask_wr)
    );

    ic_mask_reg #(
        .LINES      (LINES),
        .MASK_RESET (MASK_RESET)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mask_wr),
        .load_val (reg_wdata),
        .mask     (en_mask)
    );

    ic_route #(
        .LINES     (LINES),
        .FAST_LINE (FAST_LINE)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (masked),
        .req_normal (req_normal),
        .req_fast   (req_fast)
    );

    ic_readback #(
        .DATA_W (LINES)
    ) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (reg_rd),
        .sel        (sel),
        .status_val (masked),
        .enable_val (en_mask),
        .rdata      (reg_rdata)
    );

endmodule

// File: rtl/ic_fast_split_chk.sv
// Property checker for ic_fast_split, bound to every instance.
// Assumes the default 32 lines and offsets 0x44 / 0x48.
module ic_fast_split_chk #(
    parameter int unsigned      LINES      = 32,
    parameter int unsigned      FAST_LINE  = 8,
    parameter int unsigned      ADDR_W     = 8,
    parameter int unsigned      STATUS_OFS = 8'h44,
    parameter int unsigned      ENABLE_OFS = 8'h48,
    parameter logic [LINES-1:0] MASK_RESET = 32'hFFFE_F7FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINES-1:0]  irq_lines,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [LINES-1:0]  reg_wdata,
    input logic [LINES-1:0]  reg_rdata,
    input logic              req_normal,
    input logic              req_fast,
    input logic [LINES-1:0]  en_mask
);

    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(ENABLE_OFS);
    localparam logic [LINES-1:0]  NORM_SEL = ~(LINES'(1) << FAST_LINE);

    logic past_ok;

    // Marks that one cycle out of reset has been sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_FAST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> req_fast == $past(irq_lines[FAST_LINE] & en_mask[FAST_LINE])); // R2
    AST_NORMAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> req_normal == $past(|(irq_lines & en_mask & NORM_SEL))); // R3
    AST_MASK_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> en_mask == MASK_RESET); // R10
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_wr && reg_addr == EN_A) |-> en_mask == $past(reg_wdata)); // R7
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(reg_wr && reg_addr == EN_A) |-> $stable(en_mask)); // R8
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_rd && reg_addr == ST_A) |-> reg_rdata == $past(irq_lines & en_mask)); // R5
    AST_OTHER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_rd && reg_addr != ST_A && reg_addr != EN_A) |-> reg_rdata == '0); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(reg_rd) |-> $stable(reg_rdata)); // R11

endmodule

bind ic_fast_split ic_fast_split_chk #(
    .LINES      (LINES),
    .FAST_LINE  (FAST_LINE),
    .ADDR_W     (ADDR_W),
    .STATUS_OFS (STATUS_OFS),
    .ENABLE_OFS (ENABLE_OFS),
    .MASK_RESET (MASK_RESET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lines  (irq_lines),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .req_normal (req_normal),
    .req_fast   (req_fast),
    .en_mask    (en_mask)
);

// File: tb/test_ic_fast_split.sv
// Bench for ic_fast_split: directed corner cases plus seeded random steps,
// judged against a cycle model kept in the bench.
module test_ic_fast_split;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_normal;
    logic        req_fast;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic        done = 1'b0;

    logic [31:0] m_mask;
    logic [31:0] m_rdata;

    always #2 clk = ~clk;

    ic_fast_split i_ic_fast_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lines  (irq_lines),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .req_normal (req_normal),
        .req_fast   (req_fast)
    );

    function automatic logic [31:0] read_model(input logic [7:0] a,
                                               input logic [31:0] lines,
                                               input logic [31:0] mask);
        if (a == 8'h44) return lines & mask;
        if (a == 8'h48) return mask;
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample just after the rising edge.
    task automatic step(input logic [31:0] lines, input logic wr, input logic rd,
                        input logic [7:0] a, input logic [31:0] wd);
        logic exp_fast;
        logic exp_norm;
        string rtag;
        @(negedge clk);
        irq_lines = lines; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        exp_fast = lines[8] & m_mask[8];
        exp_norm = |(lines & m_mask & ~32'h100);
        if (rd) m_rdata = read_model(a, lines, m_mask);
        rtag = !rd ? "R11 hold" : (a == 8'h44) ? "R5 status" :
               (a == 8'h48) ? "R6/R7 enable" : "R9 other";
        if (wr && a == 8'h48) m_mask = wd;
        @(posedge clk);
        #1;
        chk("R2 R4 fast", {31'b0, req_fast}, {31'b0, exp_fast});
        chk("R3 R4 normal", {31'b0, req_normal}, {31'b0, exp_norm});
        chk(rtag, reg_rdata, m_rdata);
    endtask

    initial begin
        #(4 * 60000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_mask  = 32'hFFFE_F7FF;
        m_rdata = 32'h0;
        irq_lines = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        // R10: outputs and read data stay low during reset even with lines high.
        chk("R10 fast in reset", {31'b0, req_fast}, 32'h0);
        chk("R10 normal in reset", {31'b0, req_normal}, 32'h0);
        chk("R10 rdata in reset", reg_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_lines = '0;
        // R10: mask reset pattern visible through the enable read.
        step(32'h0, 1'b0, 1'b1, 8'h48, 32'h0);
        chk("R10 mask reset", reg_rdata, 32'hFFFE_F7FF);
        // R10: lines 11 and 16 are disabled after reset.
        step(32'h0001_0800, 1'b0, 1'b1, 8'h44, 32'h0);
        step(32'h0001_0800, 1'b0, 1'b0, 8'h44, 32'h0);
        chk("R10 lines 11,16 off", {31'b0, req_normal}, 32'h0);
        // R2: line 8 alone raises only the fast request.
        step(32'h0000_0100, 1'b0, 1'b0, 8'h00, 32'h0);
        step(32'h0000_0100, 1'b0, 1'b1, 8'h44, 32'h0);
        chk("R2 fast only", {30'b0, req_fast, req_normal}, 32'h2);
        // R1: drop line 8, status bit clears on the next read.
        step(32'h0, 1'b0, 1'b1, 8'h44, 32'h0);
        chk("R1 status clears", reg_rdata, 32'h0);
        // R3: line 0 raises only the normal request.
        step(32'h0000_0001, 1'b0, 1'b0, 8'h00, 32'h0);
        step(32'h0000_0001, 1'b0, 1'b0, 8'h00, 32'h0);
        chk("R3 normal only", {30'b0, req_fast, req_normal}, 32'h1);
        // R7: same-cycle write and read of the mask returns the old mask.
        step(32'h0000_0101, 1'b1, 1'b1, 8'h48, 32'h0000_0100);
        chk("R7 old mask on same-cycle read", reg_rdata, 32'hFFFE_F7FF);
        // R4: new mask gates outputs from the following edge.
        step(32'h0000_0101, 1'b0, 1'b1, 8'h48, 32'h0);
        chk("R4 normal masked next cycle", {31'b0, req_normal}, 32'h0);
        // R8: a write to the status offset leaves the mask unchanged.
        step(32'h0, 1'b1, 1'b0, 8'h44, 32'hDEAD_BEEF);
        step(32'h0, 1'b0, 1'b1, 8'h48, 32'h0);
        chk("R8 mask unchanged", reg_rdata, 32'h0000_0100);
        // R9: an unused offset reads zero.
        step(32'hFFFF_FFFF, 1'b0, 1'b1, 8'h40, 32'h0);
        chk("R9 other reads zero", reg_rdata, 32'h0);
        // R11: with no read strobe the read data holds.
        step(32'hFFFF_FFFF, 1'b0, 1'b0, 8'h48, 32'h0);
        chk("R11 hold", reg_rdata, 32'h0);
        // Mixed random traffic.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            logic [7:0]  a;
            r = $urandom;
            case (r[1:0])
                2'd0:    a = 8'h44;
                2'd1:    a = 8'h48;
                2'd2:    a = 8'h48;
                default: a = 8'($urandom);
            endcase
            step($urandom & $urandom, r[2] & r[3], r[4], a, $urandom);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule